// File: doc/BRIEF.md
# Paged Address Translation Unit

This block sits between a host memory bus and a shared system RAM. Every host byte address is split into a virtual page number (the upper ten bits) and a five-bit offset within a 32-byte page. For each host request the block first reads a 16-bit page descriptor from a table kept in the same RAM. It then makes a second RAM access to the byte inside the page frame that the descriptor names. The table's location is a loadable register. The region that holds the page frames begins at a fixed byte address set by a parameter.

When a descriptor says the page is not resident, the host is not aborted. The block keeps the host waiting in the middle of its cycle. It raises a fault interrupt that carries the missing page number and passes the whole RAM port to a management processor. That processor fills the frame and fixes the descriptor by whatever means it likes. It then strobes a resume input. Ownership of the bus returns to the host, and the original request is replayed from the descriptor read onward. The host never owns the RAM at the same time as the manager.

The RAM is 16 bits wide and word addressed, with a byte enable per lane and one cycle of read latency. A descriptor is one RAM word whose low byte is bits 7:0.

Top module: `page_xlat`

## Requirements
- R1: While rst_n is low, host_ready, host_wait, fault_irq, mgmt_grant and ram_we are all 0.
- R2: In the cycle after a request is accepted, the RAM port performs a read (ram_we = 0) of word address table_word + vpn. Here vpn = host_addr[14:5] and table_word is the current value of the table base register.
- R3: A descriptor is valid when its bit 15 is 1. Its bits 6:0 give the frame number and bits 14:7 are ignored. In the cycle after the descriptor read, a valid descriptor drives ram_addr to (0x1000 + frame*32 + host_addr[4:0]) >> 1.
- R4: For a read, host_ready is a one-cycle pulse in the cycle after the data access. host_rdata then holds the byte from lane 0 (bits 7:0) when the physical byte address is even, and from lane 1 (bits 15:8) when it is odd. host_wait is high from acceptance until that pulse.
- R5: For a write on a valid page, the data access has ram_we = 1 and ram_be one-hot on the addressed lane (bit 0 for an even physical address). ram_wdata carries the host byte on both lanes, and host_ready pulses in the next cycle. A later read of the same host address returns the byte.
- R6: When a descriptor has bit 15 = 0, no RAM write takes place in the decode cycle. In the next cycle fault_irq and mgmt_grant go high and fault_vpn shows the page number. host_ready stays low and host_wait stays high until resume is pulsed.
- R7: While mgmt_grant is high, ram_addr, ram_we, ram_be and ram_wdata follow mgmt_addr, mgmt_we, mgmt_be and mgmt_wdata.
- R8: A resume pulse during a fault drops fault_irq and mgmt_grant in the next cycle. In that same cycle the descriptor read is issued again, and the request then completes as in R3 to R5.
- R9: A resume pulse while no fault is pending has no effect: fault_irq and mgmt_grant stay low and the next access behaves normally.
- R10: A cfg_we pulse loads cfg_tbl_word into the table base register. Every descriptor read issued after that edge uses the new base, including a replay started by a resume in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the table base register |
| cfg_tbl_word | input | 15 | New table base, as a RAM word address |
| host_req | input | 1 | Host request, held until host_ready |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 15 | Host virtual byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, valid with host_ready |
| host_ready | output | 1 | One-cycle completion strobe |
| host_wait | output | 1 | Host is being held |
| fault_irq | output | 1 | Page fault pending |
| fault_vpn | output | 10 | Virtual page number of the pending fault |
| resume | input | 1 | One-cycle strobe from the manager to end a fault |
| mgmt_grant | output | 1 | The manager owns the RAM port |
| mgmt_addr | input | 15 | Manager RAM word address |
| mgmt_we | input | 1 | Manager write enable |
| mgmt_be | input | 2 | Manager byte enables |
| mgmt_wdata | input | 16 | Manager write data |
| ram_addr | output | 15 | RAM word address |
| ram_we | output | 1 | RAM write enable |
| ram_be | output | 2 | RAM byte-lane enables |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, one cycle after the address |

## Verification
Two functions can land in the same clock edge: the manager's resume, which ends a fault, and a load of the table base register. The bench provokes this by letting a request fault on a page that is absent in the first table. It then pulses resume and cfg_we together, pointing the base at a second table in which that page is present. The outcome is judged at the RAM port. The replayed descriptor read must appear at the new base plus the page number. The data access and the returned byte must then follow the second table's frame, not the first.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  // Sequencer phases of one host access
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,  // waiting for a host request
    S_ISSUE = 3'd1,  // descriptor read on the RAM port
    S_CHECK = 3'd2,  // descriptor arrives; data access or fault
    S_RESP  = 3'd3,  // completion strobe to the host
    S_FAULT = 3'd4   // manager owns the RAM port
  } pxl_state_e;
endpackage

// File: rtl/pxl_walk.sv
// Address arithmetic: descriptor location and physical data location
module pxl_walk #(
  parameter int          VA_W       = 15,
  parameter int          OFF_W      = 5,
  parameter int          FRAME_W    = 7,
  parameter int          PA_W       = 16,
  parameter int          LANE_W     = 1,
  parameter int unsigned FRAME_BASE = 32'h1000,
  localparam int         VPN_W      = VA_W - OFF_W,
  localparam int         WA_W       = PA_W - LANE_W
) (
  input  logic [WA_W-1:0]    tbl_word_i,
  input  logic [VA_W-1:0]    va_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [VPN_W-1:0]   vpn_o,
  output logic [WA_W-1:0]    entry_waddr_o,
  output logic [WA_W-1:0]    data_waddr_o,
  output logic [LANE_W-1:0]  lane_o
);
  logic [PA_W-1:0] phys;

  always_comb begin
    vpn_o         = va_i[VA_W-1:OFF_W];
    entry_waddr_o = tbl_word_i + WA_W'(vpn_o);
    phys          = PA_W'(FRAME_BASE) + PA_W'({frame_i, va_i[OFF_W-1:0]});
    data_waddr_o  = phys[PA_W-1:LANE_W];
    lane_o        = phys[LANE_W-1:0];
  end
endmodule

// File: rtl/pxl_seq.sv
// Access sequencer: descriptor fetch, data access, fault hold and replay
module pxl_seq (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_req,
  input  logic                  entry_valid,
  input  logic                  resume,
  output pxl_pkg::pxl_state_e   state_o
);
  import pxl_pkg::*;

  pxl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (host_req) state_d = S_ISSUE;
      S_ISSUE: state_d = S_CHECK;
      S_CHECK: state_d = entry_valid ? S_RESP : S_FAULT;
      S_RESP:  state_d = S_IDLE;
      S_FAULT: if (resume) state_d = S_ISSUE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/pxl_port.sv
// RAM port ownership: host path normally, manager path during a fault
module pxl_port #(
  parameter int WA_W  = 15,
  parameter int LANES = 2
) (
  input  logic                 grant,
  input  logic [WA_W-1:0]      h_addr,
  input  logic                 h_we,
  input  logic [LANES-1:0]     h_be,
  input  logic [LANES*8-1:0]   h_wdata,
  input  logic [WA_W-1:0]      m_addr,
  input  logic                 m_we,
  input  logic [LANES-1:0]     m_be,
  input  logic [LANES*8-1:0]   m_wdata,
  output logic [WA_W-1:0]      ram_addr,
  output logic                 ram_we,
  output logic [LANES-1:0]     ram_be,
  output logic [LANES*8-1:0]   ram_wdata
);
  always_comb begin
    if (grant) begin
      ram_addr  = m_addr;
      ram_we    = m_we;
      ram_be    = m_be;
      ram_wdata = m_wdata;
    end else begin
      ram_addr  = h_addr;
      ram_we    = h_we;
      ram_be    = h_be;
      ram_wdata = h_wdata;
    end
  end
endmodule

// File: rtl/page_xlat.sv
// Paged address translation unit, top level
module page_xlat #(
  parameter int          VA_W       = 15,
  parameter int          OFF_W      = 5,
  parameter int          FRAME_W    = 7,
  parameter int          PA_W       = 16,
  parameter int          ENTRY_W    = 16,
  parameter int          VALID_BIT  = 15,
  parameter int unsigned FRAME_BASE = 32'h1000
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [PA_W-$clog2(ENTRY_W/8)-1:0]    cfg_tbl_word,
  input  logic                                 host_req,
  input  logic                                 host_we,
  input  logic [VA_W-1:0]                      host_addr,
  input  logic [7:0]                           host_wdata,
  output logic [7:0]                           host_rdata,
  output logic                                 host_ready,
  output logic                                 host_wait,
  output logic                                 fault_irq,
  output logic [VA_W-OFF_W-1:0]                fault_vpn,
  input  logic                                 resume,
  output logic                                 mgmt_grant,
  input  logic [PA_W-$clog2(ENTRY_W/8)-1:0]    mgmt_addr,
  input  logic                                 mgmt_we,
  input  logic [ENTRY_W/8-1:0]                 mgmt_be,
  input  logic [ENTRY_W-1:0]                   mgmt_wdata,
  output logic [PA_W-$clog2(ENTRY_W/8)-1:0]    ram_addr,
  output logic                                 ram_we,
  output logic [ENTRY_W/8-1:0]                 ram_be,
  output logic [ENTRY_W-1:0]                   ram_wdata,
  input  logic [ENTRY_W-1:0]                   ram_rdata
);
  import pxl_pkg::*;

  localparam int LANES  = ENTRY_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int WA_W   = PA_W - LANE_W;
  localparam int VPN_W  = VA_W - OFF_W;

  pxl_state_e state;

  // Registers and their next values
  logic [WA_W-1:0]   tbl_word_q,  tbl_word_d;
  logic [VA_W-1:0]   req_addr_q,  req_addr_d;
  logic              req_we_q,    req_we_d;
  logic [7:0]        req_wdata_q, req_wdata_d;
  logic [VPN_W-1:0]  fvpn_q,      fvpn_d;
  logic [LANE_W-1:0] rd_lane_q,   rd_lane_d;

  // Walk results
  logic [VPN_W-1:0]  vpn;
  logic [WA_W-1:0]   entry_waddr;
  logic [WA_W-1:0]   data_waddr;
  logic [LANE_W-1:0] lane;
  logic              entry_valid;

  // Host-side RAM access
  logic [WA_W-1:0]    h_addr;
  logic               h_we;
  logic [LANES-1:0]   h_be;
  logic [LANES-1:0]   lane_hit;
  logic [ENTRY_W-1:0] h_wdata;
  logic [7:0]         lane_byte [LANES];

  assign entry_valid = ram_rdata[VALID_BIT];

  pxl_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .entry_valid (entry_valid),
    .resume      (resume),
    .state_o     (state)
  );

  pxl_walk #(
    .VA_W       (VA_W),
    .OFF_W      (OFF_W),
    .FRAME_W    (FRAME_W),
    .PA_W       (PA_W),
    .LANE_W     (LANE_W),
    .FRAME_BASE (FRAME_BASE)
  ) u_walk (
    .tbl_word_i    (tbl_word_q),
    .va_i          (req_addr_q),
    .frame_i       (ram_rdata[FRAME_W-1:0]),
    .vpn_o         (vpn),
    .entry_waddr_o (entry_waddr),
    .data_waddr_o  (data_waddr),
    .lane_o        (lane)
  );

  // Per-lane enables and read byte selection
  for (genvar li = 0; li < LANES; li++) begin : g_lane
    assign lane_hit[li]  = (lane == LANE_W'(li));
    assign lane_byte[li] = ram_rdata[li*8 +: 8];
  end

  assign h_wdata = {LANES{req_wdata_q}};

  always_comb begin
    h_addr = entry_waddr;
    h_we   = 1'b0;
    h_be   = '0;
    if (state == S_CHECK && entry_valid) begin
      h_addr = data_waddr;
      h_we   = req_we_q;
      h_be   = req_we_q ? lane_hit : '0;
    end
  end

  pxl_port #(
    .WA_W  (WA_W),
    .LANES (LANES)
  ) u_port (
    .grant     (mgmt_grant),
    .h_addr    (h_addr),
    .h_we      (h_we),
    .h_be      (h_be),
    .h_wdata   (h_wdata),
    .m_addr    (mgmt_addr),
    .m_we      (mgmt_we),
    .m_be      (mgmt_be),
    .m_wdata   (mgmt_wdata),
    .ram_addr  (ram_addr),
    .ram_we    (ram_we),
    .ram_be    (ram_be),
    .ram_wdata (ram_wdata)
  );

  // Next-state logic for the capture registers
  always_comb begin
    tbl_word_d  = tbl_word_q;
    req_addr_d  = req_addr_q;
    req_we_d    = req_we_q;
    req_wdata_d = req_wdata_q;
    fvpn_d      = fvpn_q;
    rd_lane_d   = rd_lane_q;
    if (cfg_we) tbl_word_d = cfg_tbl_word;
    if (state == S_IDLE && host_req) begin
      req_addr_d  = host_addr;
      req_we_d    = host_we;
      req_wdata_d = host_wdata;
    end
    if (state == S_CHECK) begin
      rd_lane_d = lane;
      if (!entry_valid) fvpn_d = vpn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_word_q  <= '0;
      req_addr_q  <= '0;
      req_we_q    <= 1'b0;
      req_wdata_q <= '0;
      fvpn_q      <= '0;
      rd_lane_q   <= '0;
    end else begin
      tbl_word_q  <= tbl_word_d;
      req_addr_q  <= req_addr_d;
      req_we_q    <= req_we_d;
      req_wdata_q <= req_wdata_d;
      fvpn_q      <= fvpn_d;
      rd_lane_q   <= rd_lane_d;
    end
  end

  // Host-facing outputs
  assign host_ready = (state == S_RESP);
  assign host_wait  = (state == S_ISSUE) || (state == S_CHECK) || (state == S_FAULT);
  assign fault_irq  = (state == S_FAULT);
  assign mgmt_grant = (state == S_FAULT);
  assign fault_vpn  = fvpn_q;
  assign host_rdata = (host_ready && !req_we_q) ? lane_byte[rd_lane_q] : 8'h00;
endmodule

// File: rtl/pxl_chk.sv
// Temporal checks on the translation unit's ports
module pxl_chk #(
  parameter int VPN_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_ready,
  input logic             host_wait,
  input logic             fault_irq,
  input logic [VPN_W-1:0] fault_vpn,
  input logic             mgmt_grant,
  input logic             resume,
  input logic             ram_we
);
  assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);

  assert_wait_before_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> $past(host_wait));

  assert_fault_blocks_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |-> (!host_ready && host_wait));

  assert_fault_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_irq) |-> $past(!ram_we));

  assert_vpn_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_irq && $past(fault_irq)) |-> $stable(fault_vpn));

  assert_grant_no_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_grant |-> !host_ready);

  assert_release_on_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_irq && resume) |=> (!mgmt_grant && !fault_irq && host_wait));

  assert_stray_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_irq && !host_wait && resume) |=> !fault_irq);
endmodule

bind page_xlat pxl_chk #(.VPN_W(VA_W - OFF_W)) u_pxl_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_ready (host_ready),
  .host_wait  (host_wait),
  .fault_irq  (fault_irq),
  .fault_vpn  (fault_vpn),
  .mgmt_grant (mgmt_grant),
  .resume     (resume),
  .ram_we     (ram_we)
);

// File: tb/page_xlat_tb_top.sv
`timescale 1ns/1ps
module page_xlat_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [14:0] cfg_tbl_word;
  logic        host_req, host_we;
  logic [14:0] host_addr;
  logic [7:0]  host_wdata, host_rdata;
  logic        host_ready, host_wait, fault_irq, resume, mgmt_grant;
  logic [9:0]  fault_vpn;
  logic [14:0] mgmt_addr, ram_addr;
  logic        mgmt_we, ram_we;
  logic [1:0]  mgmt_be, ram_be;
  logic [15:0] mgmt_wdata, ram_wdata, ram_rdata;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  logic        tb_init;
  logic [15:0] mem [0:4095];
  bit          fixed0 [0:1023];
  logic [7:0]  wshadow [int];
  int          cur_base_w = 0;

  always #2.5 clk = ~clk;

  page_xlat dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tbl_word(cfg_tbl_word),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ready(host_ready),
    .host_wait(host_wait), .fault_irq(fault_irq), .fault_vpn(fault_vpn),
    .resume(resume), .mgmt_grant(mgmt_grant), .mgmt_addr(mgmt_addr),
    .mgmt_we(mgmt_we), .mgmt_be(mgmt_be), .mgmt_wdata(mgmt_wdata),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_be(ram_be),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // First table: every third page absent; bits 14:7 carry filler
  function automatic logic [15:0] ent0(int v);
    logic [7:0] vb = 8'(v);
    return {((v % 3) != 2), vb, 7'((v * 5 + 1) % 128)};
  endfunction

  // Second table: all pages present, different frames
  function automatic logic [15:0] ent1(int v);
    logic [7:0] vb = ~8'(v);
    return {1'b1, vb, 7'((v * 11 + 3) % 128)};
  endfunction

  function automatic logic [15:0] mem_init(int w);
    if (w < 1024)      return ent0(w);
    else if (w < 2048) return ent1(w - 1024);
    else               return 16'(w * 40503 + 12345);
  endfunction

  function automatic logic [15:0] exp_entry(int v);
    if (cur_base_w == 0) return fixed0[v] ? (ent0(v) | 16'h8000) : ent0(v);
    else                 return ent1(v);
  endfunction

  // RAM model: one-cycle read latency, per-lane write enables
  always @(posedge clk) begin
    if (tb_init) begin
      for (int i = 0; i < 4096; i++) mem[i] <= mem_init(i);
    end else if (ram_we) begin
      for (int b = 0; b < 2; b++)
        if (ram_be[b]) mem[ram_addr[11:0]][b*8 +: 8] <= ram_wdata[b*8 +: 8];
    end
    ram_rdata <= mem[ram_addr[11:0]];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  // One host access, with fault service when the descriptor is absent
  task automatic access(input int a, input bit we, input logic [7:0] wd, input bit swap);
    int v = a >> 5;
    int off = a & 31;
    int ewa, ph;
    logic [15:0] e, word;
    logic [7:0]  eb;
    @(negedge clk);
    host_req = 1; host_we = we; host_addr = 15'(a); host_wdata = wd;
    @(negedge clk);                       // descriptor read cycle
    ewa = cur_base_w + v;
    chk("R2 entry address", ram_addr, ewa);
    chk("R2 entry read only", ram_we, 0);
    chk("R4 wait during access", host_wait, 1);
    @(negedge clk);                       // decode cycle
    e = exp_entry(v);
    if (!e[15]) begin
      chk("R6 no write on absent page", ram_we, 0);
      @(negedge clk);
      chk("R6 fault_irq", fault_irq, 1);
      chk("R6 mgmt_grant", mgmt_grant, 1);
      chk("R6 fault_vpn", fault_vpn, v);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk("R6 host held", {host_ready, host_wait}, 2'b01);
      end
      if (swap) begin
        resume = 1; cfg_we = 1; cfg_tbl_word = 15'h400;   // R10 same cycle
      end else begin
        mgmt_we = 1; mgmt_addr = 15'(ewa); mgmt_be = 2'b11; mgmt_wdata = e | 16'h8000;
        #1;
        chk("R7 manager address", ram_addr, ewa);
        chk("R7 manager write", {ram_we, ram_be}, 3'b111);
        chk("R7 manager data", ram_wdata, e | 16'h8000);
        @(negedge clk);
        mgmt_we = 0; fixed0[v] = 1; resume = 1;
      end
      @(negedge clk);
      resume = 0; cfg_we = 0;
      if (swap) cur_base_w = 'h400;
      ewa = cur_base_w + v;
      chk("R8 fault released", {fault_irq, mgmt_grant}, 2'b00);
      chk("R8 replay entry address (R10 base)", ram_addr, ewa);
      chk("R8 replay read only", ram_we, 0);
      @(negedge clk);
      e = exp_entry(v);
    end
    ph = 'h1000 + int'(e[6:0]) * 32 + off;
    chk("R3 data address", ram_addr, ph >> 1);
    chk("R5 data write enable", ram_we, we);
    if (we) begin
      chk("R5 lane enable", ram_be, (ph & 1) ? 2'b10 : 2'b01);
      chk("R5 replicated data", ram_wdata, {wd, wd});
      wshadow[ph] = wd;
    end
    @(negedge clk);
    chk("R4 ready strobe", host_ready, 1);
    if (!we) begin
      word = mem_init(ph >> 1);
      eb = (ph & 1) ? word[15:8] : word[7:0];
      if (wshadow.exists(ph)) eb = wshadow[ph];
      chk("R4 read byte", host_rdata, eb);
    end
    host_req = 0;
    @(negedge clk);
    chk("R4 ready is one cycle", host_ready, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    rst_n = 0; tb_init = 1; cfg_we = 0; cfg_tbl_word = '0;
    host_req = 0; host_we = 0; host_addr = '0; host_wdata = '0;
    resume = 0; mgmt_we = 0; mgmt_addr = '0; mgmt_be = '0; mgmt_wdata = '0;
    for (int i = 0; i < 1024; i++) fixed0[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {host_ready, host_wait, fault_irq, mgmt_grant, ram_we}, 5'b0);
    tb_init = 0; rst_n = 1;
    @(negedge clk);

    // R9: stray resume
    resume = 1;
    @(negedge clk);
    resume = 0;
    chk("R9 no fault from stray resume", {fault_irq, mgmt_grant, host_wait}, 3'b000);
    @(negedge clk);
    chk("R9 still idle", {fault_irq, mgmt_grant}, 2'b00);
    access(1 * 32 + 6, 0, 8'h00, 0);      // R9 next access normal

    // R10 + R8: resume and base load in the same cycle
    access(2 * 32 + 7, 0, 8'h00, 1);
    @(negedge clk); cfg_we = 1; cfg_tbl_word = 15'h000;
    @(negedge clk); cfg_we = 0; cur_base_w = 0;

    // Full sweep of the first table (faults serviced by the manager)
    for (int v = 0; v < 1024; v++) access(v * 32 + (v * 3) % 32, 0, 8'h00, 0);

    // R5 writes on both lanes, then read back
    for (int v = 0; v < 24; v++) access(v * 32 + (v * 7) % 32, 1, 8'(v * 13 + 5), 0);
    for (int v = 0; v < 24; v++) access(v * 32 + (v * 7) % 32, 0, 8'h00, 0);

    // R10: switch to the second table
    @(negedge clk); cfg_we = 1; cfg_tbl_word = 15'h400;
    @(negedge clk); cfg_we = 0; cur_base_w = 'h400;
    for (int v = 0; v < 64; v++) access(v * 32 + 31 - (v % 32), 0, 8'h00, 0);

    done = 1;
    summary();
  end
endmodule